// File: doc/BRIEF.md
# Output Voltage Fault Supervisor

This block watches the digitized readings of a multi-phase buck regulator and decides when the output is healthy. Each clock edge is one sample. On each sample it compares the sensed output voltage with windows that move with the reference code. It compares the current-sum reading with an overcurrent limit. It also checks the remote sense lines for an open connection by comparing the inductor-side reference reading with the differential amplifier output. All codes are unsigned, with 1 LSB = 1 mV.

The supervisor drives a power-good flag and four fault flags. It also drives a clamp request that tells the gate drivers to turn on every low-side switch, so that a rising output is pulled down instead of left floating. While the controller is disabled, the overvoltage check uses a fixed ceiling that depends on the reference standard. Overvoltage and overcurrent stay latched until the enable is cycled.

Top module: `svf_top`

## Requirements
- R1: Undervoltage (`uv_flag`) sets when `vsen_code*100 < vref_code*82`. It is monitored only while `en` and `ss_done` are both high, and is held clear otherwise.
- R2: Once set, undervoltage clears only when `vsen_code*100 >= vref_code*85`. Readings between the two limits leave it set.
- R3: While `en` is high, overvoltage (`ov_flag`) sets when `vsen_code > vref_code + 150`.
- R4: While `en` is low, the overvoltage limit is fixed: 1970 when `ref_std` = 0, and 1670 for any other `ref_std` value. This limit drives both `ov_flag` and `lo_clamp`.
- R5: `lo_clamp` sets together with an overvoltage detection. It releases only when `vsen_code` drops below the active overvoltage limit minus 50, and sets again if the voltage rises once more.
- R6: Overcurrent (`oc_flag`) sets when `en` is high and `isum_code > ocset_code`.
- R7: `ov_flag` and `oc_flag` stay set after their condition goes away. They clear, together with `lo_clamp`, on the first sample at which `en` is high after having been low.
- R8: Open sense (`osense_flag`) sets when `iref_code > vdiff_code + 1000` while `en` is high. It clears after the condition has been absent for two samples, and is held clear while `en` is low.
- R9: Every set and every release needs its condition on two consecutive samples. A single-sample excursion changes no flag.
- R10: `pgood` is low until `ss_done` and `en` are high. It rises on the first clock edge at which `ss_done` is seen high with no fault present.
- R11: `pgood` falls on the same edge at which any of `uv_flag`, `ov_flag`, `oc_flag` or `osense_flag` becomes set, and stays low while any of them is set.
- R12: Synchronous reset clears `pgood`, all flags and `lo_clamp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable |
| ss_done | input | 1 | Soft-start has finished |
| ref_std | input | 2 | Reference standard; 0 selects the high disabled-state overvoltage limit |
| vsen_code | input | 12 | Sensed output voltage, mV |
| vref_code | input | 12 | Reference voltage, mV |
| isum_code | input | 12 | Current-sum reading |
| ocset_code | input | 12 | Overcurrent limit reading |
| iref_code | input | 12 | Sense-line reference reading, mV |
| vdiff_code | input | 12 | Differential amplifier output, mV |
| pgood | output | 1 | Output in regulation |
| uv_flag | output | 1 | Undervoltage |
| ov_flag | output | 1 | Latched overvoltage |
| oc_flag | output | 1 | Latched overcurrent |
| osense_flag | output | 1 | Open remote-sense connection |
| lo_clamp | output | 1 | Turn all low-side switches on |

## Verification
The inline properties are checked on every cycle. They cover these relations:
- a flag may rise only after its set condition was present on the previous sample;
- a latched flag may fall only on an enable re-arm;
- a clamp never appears without the overvoltage flag;
- `pgood` is never high alongside a fault, or without soft-start done on the prior sample.

The actual threshold values, the width of each hysteresis band, the switch between the tracking and fixed limits on enable, and the rejection of one-sample glitches can only be shown by the bench's directed scenarios. The bench compares every output against a behavioural model on each clock.

// File: rtl/svf_pkg.sv
package svf_pkg;
  typedef enum logic [1:0] {
    STD_HI  = 2'd0,
    STD_LO1 = 2'd1,
    STD_LO2 = 2'd2,
    STD_LO3 = 2'd3
  } ref_std_e;

  // Fixed disabled-state overvoltage ceiling per reference standard
  function automatic int unsigned idle_ov_limit(ref_std_e s, int unsigned hi_mv, int unsigned lo_mv);
    return (s == STD_HI) ? hi_mv : lo_mv;
  endfunction
endpackage

// File: rtl/svf_compare.sv
module svf_compare
  import svf_pkg::*;
#(
  parameter int W          = 12,
  parameter int UV_PCT     = 82,
  parameter int UV_HYS_PCT = 3,
  parameter int OV_OFS     = 150,
  parameter int OV_HYS     = 50,
  parameter int OV_IDLE_HI = 1970,
  parameter int OV_IDLE_LO = 1670,
  parameter int OS_MARGIN  = 1000
) (
  input  logic         en,
  input  ref_std_e     std,
  input  logic [W-1:0] vsen,
  input  logic [W-1:0] vref,
  input  logic [W-1:0] isum,
  input  logic [W-1:0] ocset,
  input  logic [W-1:0] iref,
  input  logic [W-1:0] vdiff,
  output logic         uv_set,
  output logic         uv_rel,
  output logic         ov_set,
  output logic         ov_rel,
  output logic         oc_set,
  output logic         os_set
);
  localparam int PW = W + 8;
  localparam int SW = W + 2;

  logic [PW-1:0] vs_scaled, uv_lo, uv_hi;
  logic [SW-1:0] ov_on, ov_off, idle_lim;

  assign vs_scaled = PW'(vsen) * PW'(100);
  assign uv_lo     = PW'(vref) * PW'(UV_PCT);
  assign uv_hi     = PW'(vref) * PW'(UV_PCT + UV_HYS_PCT);
  assign uv_set    = vs_scaled < uv_lo;
  assign uv_rel    = vs_scaled >= uv_hi;

  assign idle_lim  = SW'(idle_ov_limit(std, OV_IDLE_HI, OV_IDLE_LO));
  assign ov_on     = en ? (SW'(vref) + SW'(OV_OFS)) : idle_lim;
  assign ov_off    = ov_on - SW'(OV_HYS);
  assign ov_set    = SW'(vsen) > ov_on;
  assign ov_rel    = SW'(vsen) < ov_off;

  assign oc_set    = en && (isum > ocset);
  assign os_set    = SW'(iref) > (SW'(vdiff) + SW'(OS_MARGIN));
endmodule

// File: rtl/svf_debounce.sv
module svf_debounce #(
  parameter bit LATCH = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic set_c,
  input  logic rel_c,
  output logic flag,
  output logic flag_nx
);
  logic set_q, rel_q;

  always_comb begin
    flag_nx = flag;
    if (flush)
      flag_nx = 1'b0;
    else if (!flag && set_c && set_q)
      flag_nx = 1'b1;
    else if (flag && !LATCH && rel_c && rel_q)
      flag_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      set_q <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      flag  <= flag_nx;
      set_q <= flush ? 1'b0 : set_c;
      rel_q <= flush ? 1'b0 : rel_c;
    end
  end

  // R9
  two_sample_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(set_c));

  generate
    if (LATCH) begin : g_latched
      // R7
      latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(flush));
    end
  endgenerate
endmodule

// File: rtl/svf_top.sv
module svf_top
  import svf_pkg::*;
#(
  parameter int W          = 12,
  parameter int UV_PCT     = 82,
  parameter int UV_HYS_PCT = 3,
  parameter int OV_OFS     = 150,
  parameter int OV_HYS     = 50,
  parameter int OV_IDLE_HI = 1970,
  parameter int OV_IDLE_LO = 1670,
  parameter int OS_MARGIN  = 1000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ss_done,
  input  logic [1:0]   ref_std,
  input  logic [W-1:0] vsen_code,
  input  logic [W-1:0] vref_code,
  input  logic [W-1:0] isum_code,
  input  logic [W-1:0] ocset_code,
  input  logic [W-1:0] iref_code,
  input  logic [W-1:0] vdiff_code,
  output logic         pgood,
  output logic         uv_flag,
  output logic         ov_flag,
  output logic         oc_flag,
  output logic         osense_flag,
  output logic         lo_clamp
);
  logic uv_s, uv_r, ov_s, ov_r, oc_s, os_s;
  logic en_q, rearm;
  logic uv_nx, ov_nx, oc_nx, os_nx, cl_nx;

  svf_compare #(
    .W(W), .UV_PCT(UV_PCT), .UV_HYS_PCT(UV_HYS_PCT), .OV_OFS(OV_OFS),
    .OV_HYS(OV_HYS), .OV_IDLE_HI(OV_IDLE_HI), .OV_IDLE_LO(OV_IDLE_LO),
    .OS_MARGIN(OS_MARGIN)
  ) u_cmp (
    .en(en), .std(ref_std_e'(ref_std)), .vsen(vsen_code), .vref(vref_code),
    .isum(isum_code), .ocset(ocset_code), .iref(iref_code), .vdiff(vdiff_code),
    .uv_set(uv_s), .uv_rel(uv_r), .ov_set(ov_s), .ov_rel(ov_r),
    .oc_set(oc_s), .os_set(os_s)
  );

  assign rearm = en && !en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= en;
  end

  svf_debounce #(.LATCH(1'b0)) u_uv (
    .clk(clk), .rst(rst), .flush(!(en && ss_done)), .set_c(uv_s), .rel_c(uv_r),
    .flag(uv_flag), .flag_nx(uv_nx));

  svf_debounce #(.LATCH(1'b1)) u_ov (
    .clk(clk), .rst(rst), .flush(rearm), .set_c(ov_s), .rel_c(1'b0),
    .flag(ov_flag), .flag_nx(ov_nx));

  svf_debounce #(.LATCH(1'b0)) u_clamp (
    .clk(clk), .rst(rst), .flush(rearm), .set_c(ov_s), .rel_c(ov_r),
    .flag(lo_clamp), .flag_nx(cl_nx));

  svf_debounce #(.LATCH(1'b1)) u_oc (
    .clk(clk), .rst(rst), .flush(rearm), .set_c(oc_s), .rel_c(1'b0),
    .flag(oc_flag), .flag_nx(oc_nx));

  svf_debounce #(.LATCH(1'b0)) u_os (
    .clk(clk), .rst(rst), .flush(!en), .set_c(os_s), .rel_c(!os_s),
    .flag(osense_flag), .flag_nx(os_nx));

  always_ff @(posedge clk) begin
    if (rst) pgood <= 1'b0;
    else     pgood <= en && ss_done && !(uv_nx || ov_nx || oc_nx || os_nx);
  end

  // R10
  pgood_ss_chk: assert property (@(posedge clk) disable iff (rst)
    pgood |-> $past(ss_done && en));

  // R11
  pgood_fault_chk: assert property (@(posedge clk) disable iff (rst)
    pgood |-> !(uv_flag || ov_flag || oc_flag || osense_flag));

  // R5
  clamp_ov_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_clamp) |-> ov_flag);

  // cl_nx is consumed only through the clamp register
  logic unused_ok;
  assign unused_ok = cl_nx;
endmodule

// File: tb/sim_svf_top.sv
module sim_svf_top;
  logic clk = 1'b0;
  logic rst, en, ss_done;
  logic [1:0] ref_std;
  logic [11:0] vsen, vref, isum, ocset, iref, vdiff;
  logic pgood, uv, ov, oc, os, clamp;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  bit m_pg, m_uv, m_ov, m_oc, m_os, m_cl, m_enp;
  bit p_uvs, p_uvr, p_ov, p_cs, p_cr, p_oc, p_os, p_or;

  always #10 clk = ~clk;

  svf_top u0 (
    .clk(clk), .rst(rst), .en(en), .ss_done(ss_done), .ref_std(ref_std),
    .vsen_code(vsen), .vref_code(vref), .isum_code(isum), .ocset_code(ocset),
    .iref_code(iref), .vdiff_code(vdiff), .pgood(pgood), .uv_flag(uv),
    .ov_flag(ov), .oc_flag(oc), .osense_flag(os), .lo_clamp(clamp));

  always @(posedge clk) begin
    int vs, vr, lim_on, lim_off;
    bit er, c_uvs, c_uvr, c_ovs, c_ovr, c_oc, c_os;
    if (rst) begin
      {m_pg, m_uv, m_ov, m_oc, m_os, m_cl, m_enp} = '0;
      {p_uvs, p_uvr, p_ov, p_cs, p_cr, p_oc, p_os, p_or} = '0;
    end else begin
      vs = int'(vsen); vr = int'(vref);
      er = en && !m_enp; m_enp = en;
      lim_on  = en ? vr + 150 : ((ref_std == 2'd0) ? 1970 : 1670);
      lim_off = lim_on - 50;
      c_uvs = vs * 100 < vr * 82;
      c_uvr = vs * 100 >= vr * 85;
      c_ovs = vs > lim_on;
      c_ovr = vs < lim_off;
      c_oc  = en && (int'(isum) > int'(ocset));
      c_os  = int'(iref) > int'(vdiff) + 1000;
      if (!(en && ss_done)) begin m_uv = 0; p_uvs = 0; p_uvr = 0; end
      else begin
        if (!m_uv && c_uvs && p_uvs) m_uv = 1;
        else if (m_uv && c_uvr && p_uvr) m_uv = 0;
        p_uvs = c_uvs; p_uvr = c_uvr;
      end
      if (er) begin m_ov = 0; p_ov = 0; m_cl = 0; p_cs = 0; p_cr = 0; m_oc = 0; p_oc = 0; end
      else begin
        if (c_ovs && p_ov) m_ov = 1;
        p_ov = c_ovs;
        if (!m_cl && c_ovs && p_cs) m_cl = 1;
        else if (m_cl && c_ovr && p_cr) m_cl = 0;
        p_cs = c_ovs; p_cr = c_ovr;
        if (c_oc && p_oc) m_oc = 1;
        p_oc = c_oc;
      end
      if (!en) begin m_os = 0; p_os = 0; p_or = 0; end
      else begin
        if (!m_os && c_os && p_os) m_os = 1;
        else if (m_os && !c_os && p_or) m_os = 0;
        p_os = c_os; p_or = !c_os;
      end
      m_pg = en && ss_done && !(m_uv || m_ov || m_oc || m_os);
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(pgood, m_pg, "R10 R11 pgood");
      chk(uv, m_uv, "R1 R2 uv");
      chk(ov, m_ov, "R3 R4 R7 ov");
      chk(oc, m_oc, "R6 R7 oc");
      chk(os, m_os, "R8 osense");
      chk(clamp, m_cl, "R5 R4 clamp");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rearm_en();
    en = 0; cyc(2); en = 1; cyc(3);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1; en = 0; ss_done = 0; ref_std = 0;
    vsen = 1200; vref = 1200; isum = 100; ocset = 500; iref = 1200; vdiff = 1200;
    cyc(3);
    // R12 reset state
    chk(pgood | uv | ov | oc | os | clamp, 1'b0, "R12 reset");
    rst = 0; en = 1; cyc(4);
    chk(pgood, 1'b0, "R10 before soft-start");
    ss_done = 1; cyc(1);
    chk(pgood, 1'b1, "R10 rise after soft-start");
    // R9 single-sample glitch below UV limit (984)
    vsen = 900; cyc(1); vsen = 1200; cyc(3);
    chk(uv, 1'b0, "R9 glitch rejected");
    vsen = 900; cyc(3);
    chk(uv, 1'b1, "R1 undervoltage");
    chk(pgood, 1'b0, "R11 pgood low on uv");
    vsen = 1010; cyc(3);
    chk(uv, 1'b1, "R2 inside hysteresis band");
    vsen = 1020; cyc(3);
    chk(uv, 1'b0, "R2 release at 85 percent");
    chk(pgood, 1'b1, "R10 pgood back");
    // R3 and R5: limit 1350, release below 1300
    vsen = 1350; cyc(3);
    chk(ov, 1'b0, "R3 at limit no trip");
    vsen = 1360; cyc(3);
    chk(ov, 1'b1, "R3 overvoltage");
    chk(clamp, 1'b1, "R5 clamp on");
    vsen = 1310; cyc(3);
    chk(clamp, 1'b1, "R5 clamp held in band");
    vsen = 1200; cyc(3);
    chk(clamp, 1'b0, "R5 clamp released");
    chk(ov, 1'b1, "R7 ov latched");
    vsen = 1400; cyc(3);
    chk(clamp, 1'b1, "R5 clamp reasserts");
    vsen = 1200; cyc(3);
    rearm_en();
    chk(ov, 1'b0, "R7 ov cleared by rearm");
    // R6 overcurrent
    isum = 600; cyc(3);
    chk(oc, 1'b1, "R6 overcurrent");
    chk(pgood, 1'b0, "R11 pgood low on oc");
    isum = 100; cyc(3);
    chk(oc, 1'b1, "R7 oc latched");
    rearm_en();
    chk(oc, 1'b0, "R7 oc cleared by rearm");
    chk(pgood, 1'b1, "R10 pgood after rearm");
    // R8 open sense: margin 1000
    vdiff = 200; cyc(3);
    chk(os, 1'b0, "R8 at margin no trip");
    vdiff = 100; cyc(3);
    chk(os, 1'b1, "R8 open sense");
    vdiff = 1200; cyc(3);
    chk(os, 1'b0, "R8 open sense clears");
    // R4 disabled-state limits
    en = 0; ref_std = 2'd0; vsen = 1800; cyc(3);
    chk(clamp, 1'b0, "R4 std0 below 1970");
    ref_std = 2'd1; cyc(3);
    chk(clamp, 1'b1, "R4 std1 above 1670");
    chk(ov, 1'b1, "R4 ov while disabled");
    vsen = 1600; cyc(3);
    chk(clamp, 1'b0, "R4 release below 1620");
    ref_std = 2'd0; vsen = 2000; cyc(3);
    chk(clamp, 1'b1, "R4 std0 above 1970");
    vsen = 1200; en = 1; cyc(3);
    chk(ov | clamp, 1'b0, "R7 rearm clears");
    chk(pgood, 1'b1, "R10 final pgood");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule